// File: doc/BRIEF.md
# Environmental Auto-Shutdown Controller

This block supervises a system's environmental health flags and removes internal DC power when a damaging condition persists. It watches an over-temperature flag, a supply-voltage-fault flag and a presence flag for each power supply. A temperature or voltage fault cuts power on the next clock edge. The loss of a supply starts a grace countdown instead, and power is cut only if the supply is still missing when the countdown runs out. Once power has been cut it stays off until the operator turns the power switch off and then back on.

The whole behaviour is gated by an enable bit, which is clear in the default configuration. A second configuration bit switches off the supply-removal trip and leaves the temperature and voltage trips in force. The sensor flags are already qualified and synchronous to the block clock. The operator switch is asynchronous, so it is synchronised and debounced inside the block. The grace window is counted by a prescaler that produces one tick every `TICK_DIV` cycles and a tick counter that runs to `GRACE_TICKS`. The defaults give five minutes at 200 MHz. A simulation can use short values.

Top module: `env_shutdown_ctrl`

## Requirements
- R1: While `cfg_auto_en` is 0, nothing moves the block out of the active state: not a temperature fault, not a voltage fault, not a missing supply. `power_on` stays 1 and `crit_alarm` stays 0.
- R2: With `cfg_auto_en` = 1, a `temp_hot` seen in the active or countdown state moves the block to the tripped state at the next edge, with `power_on` = 0.
- R3: With `cfg_auto_en` = 1, a `volt_bad` seen in the active or countdown state moves the block to the tripped state at the next edge, with `power_on` = 0.
- R4: With `cfg_auto_en` = 1 and `cfg_skip_psu` = 0, a missing supply (any `psu_present` bit 0) in the active state enters countdown at the next edge, with `power_on` = 1 and `crit_alarm` = 1. If the supply is still missing, the block trips after exactly `GRACE_TICKS`*`TICK_DIV` cycles in countdown.
- R5: When every supply is present during countdown, the block returns to active at the next edge. This holds even in the countdown's final cycle. A later removal starts a full-length countdown again.
- R6: With `cfg_skip_psu` = 1, a missing supply never leaves the active state, but `temp_hot` and `volt_bad` still trip.
- R7: The tripped state is latched. Clearing faults, restoring supplies and changing the configuration have no effect. It is left only when the debounced switch reads off, which enters a re-arm state with `power_on` = 0 and `crit_alarm` = 0. From there the switch reading on returns the block to active.
- R8: A switch level that holds for fewer than `DEB_CYCLES` cycles has no effect.
- R9: `state_o` encodes active = 0, countdown = 1, tripped = 2, re-arm = 3. After reset the block is active. `crit_alarm` is 1 exactly in countdown and tripped. `power_on` is 1 exactly in active and countdown.
- R10: Clearing `cfg_auto_en` during countdown returns the block to active at the next edge.
- R11: A temperature or voltage fault takes priority over a supply-removal event arriving in the same cycle, so the block goes to tripped and not to countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_en | input | 1 | Enables automatic shutdown |
| cfg_skip_psu | input | 1 | Suppresses the supply-removal trip |
| temp_hot | input | 1 | Qualified over-temperature flag |
| volt_bad | input | 1 | Qualified supply out-of-tolerance flag |
| psu_present | input | N_PSU | One presence flag per supply, 1 = inserted |
| pwr_switch | input | 1 | Raw operator power switch, 1 = on |
| power_on | output | 1 | Enable for internal DC power |
| crit_alarm | output | 1 | Critical alarm indication |
| state_o | output | 2 | Current controller state (see R9) |

## Verification
Three pairs of events can land in the same cycle. The bench drives a temperature fault in the same cycle as a supply removal and expects a trip, not a countdown. It also restores the supplies in the exact cycle in which the grace counter expires and expects the countdown to be cancelled rather than the block to trip. It then clears the enable during a countdown and expects the block to fall back to active. A long random run toggles faults, presence bits and configuration bits together. Every cycle it compares the status, power and alarm outputs with a cycle-counting reference model in the bench.

// File: rtl/esd_pkg.sv
package esd_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE    = 2'd0,
        ST_COUNTDOWN = 2'd1,
        ST_TRIPPED   = 2'd2,
        ST_REARM     = 2'd3
    } esd_state_e;
endpackage

// File: rtl/esd_switch_filter.sv
module esd_switch_filter #(
    parameter int DEB_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_raw,
    output logic sw_level
);
    localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = sw_raw;
        r_d.s2 = r_q.s1;
        if (r_q.s2 == r_q.level) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CNT_LAST) begin
            r_d.level = r_q.s2;
            r_d.cnt   = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: 1'b1, s2: 1'b1, level: 1'b1, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sw_level = r_q.level;
endmodule

// File: rtl/esd_tick_prescaler.sv
module esd_tick_prescaler #(
    parameter int TICK_DIV = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_direct
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick = run;
        end else begin : g_count
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_q, pre_d;

            always_comb begin
                if (!run || pre_q == PRE_LAST) pre_d = '0;
                else                           pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = run && (pre_q == PRE_LAST);
        end
    endgenerate
endmodule

// File: rtl/esd_grace_timer.sv
module esd_grace_timer #(
    parameter int TICK_DIV    = 200_000_000,
    parameter int GRACE_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int GW = (GRACE_TICKS > 1) ? $clog2(GRACE_TICKS) : 1;
    localparam logic [GW-1:0] TCNT_LAST = GW'(GRACE_TICKS - 1);

    logic          tick;
    logic [GW-1:0] tcnt_q, tcnt_d;

    esd_tick_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    always_comb begin
        if (!run)       tcnt_d = '0;
        else if (tick)  tcnt_d = tcnt_q + 1'b1;
        else            tcnt_d = tcnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tcnt_q <= '0;
        else        tcnt_q <= tcnt_d;
    end

    assign expire = run && tick && (tcnt_q == TCNT_LAST);
endmodule

// File: rtl/env_shutdown_ctrl.sv
module env_shutdown_ctrl
    import esd_pkg::*;
#(
    parameter int N_PSU       = 2,
    parameter int TICK_DIV    = 200_000_000,
    parameter int GRACE_TICKS = 300,
    parameter int DEB_CYCLES  = 2_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_auto_en,
    input  logic             cfg_skip_psu,
    input  logic             temp_hot,
    input  logic             volt_bad,
    input  logic [N_PSU-1:0] psu_present,
    input  logic             pwr_switch,
    output logic             power_on,
    output logic             crit_alarm,
    output logic [1:0]       state_o
);
    typedef struct packed {
        esd_state_e state;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic sw_on;
    logic grace_done;
    logic hard_fault;
    logic psu_missing;

    esd_switch_filter #(.DEB_CYCLES(DEB_CYCLES)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_raw  (pwr_switch),
        .sw_level(sw_on)
    );

    esd_grace_timer #(.TICK_DIV(TICK_DIV), .GRACE_TICKS(GRACE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.state == ST_COUNTDOWN),
        .expire(grace_done)
    );

    assign hard_fault  = cfg_auto_en && (temp_hot || volt_bad);
    assign psu_missing = cfg_auto_en && !cfg_skip_psu && !(&psu_present);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_ACTIVE: begin
                if (hard_fault)       ctl_d.state = ST_TRIPPED;
                else if (psu_missing) ctl_d.state = ST_COUNTDOWN;
            end
            ST_COUNTDOWN: begin
                if (hard_fault)        ctl_d.state = ST_TRIPPED;
                else if (!psu_missing) ctl_d.state = ST_ACTIVE;
                else if (grace_done)   ctl_d.state = ST_TRIPPED;
            end
            ST_TRIPPED: begin
                if (!sw_on) ctl_d.state = ST_REARM;
            end
            ST_REARM: begin
                if (sw_on) ctl_d.state = ST_ACTIVE;
            end
            default: ctl_d.state = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_ACTIVE};
        else        ctl_q <= ctl_d;
    end

    assign power_on   = (ctl_q.state == ST_ACTIVE) || (ctl_q.state == ST_COUNTDOWN);
    assign crit_alarm = (ctl_q.state == ST_COUNTDOWN) || (ctl_q.state == ST_TRIPPED);
    assign state_o    = ctl_q.state;
endmodule

// File: rtl/esd_checker.sv
module esd_checker #(
    parameter int N_PSU = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_auto_en,
    input logic             cfg_skip_psu,
    input logic             temp_hot,
    input logic             volt_bad,
    input logic [N_PSU-1:0] psu_present,
    input logic             power_on,
    input logic             crit_alarm,
    input logic [1:0]       state_o
);
    AST_DISABLED_STAYS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto_en && state_o == 2'd0) |=> state_o == 2'd0); // R1
    AST_HOT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en && temp_hot && state_o <= 2'd1) |=> state_o == 2'd2); // R2
    AST_VOLT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en && volt_bad && state_o <= 2'd1) |=> state_o == 2'd2); // R3
    AST_REMOVAL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en && !cfg_skip_psu && !temp_hot && !volt_bad && state_o == 2'd0 && !(&psu_present))
        |=> (state_o == 2'd1 && power_on && crit_alarm)); // R4
    AST_REINSERT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && (&psu_present) && !temp_hot && !volt_bad) |=> state_o == 2'd0); // R5
    AST_SKIP_PSU: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_skip_psu && state_o == 2'd0) |=> state_o != 2'd1); // R6
    AST_TRIP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3)); // R7
    AST_REARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0)); // R7
    AST_POWER_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (power_on && crit_alarm) |-> state_o == 2'd1); // R9
    AST_DISABLE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && !cfg_auto_en) |=> state_o == 2'd0); // R10
endmodule

bind env_shutdown_ctrl esd_checker #(.N_PSU(N_PSU)) u_esd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_auto_en (cfg_auto_en),
    .cfg_skip_psu(cfg_skip_psu),
    .temp_hot    (temp_hot),
    .volt_bad    (volt_bad),
    .psu_present (psu_present),
    .power_on    (power_on),
    .crit_alarm  (crit_alarm),
    .state_o     (state_o)
);

// File: tb/tb_env_shutdown_ctrl.sv
`timescale 1ns/1ps
module tb_env_shutdown_ctrl;
    localparam int TD  = 4;
    localparam int GT  = 5;
    localparam int DEB = 8;
    localparam int NWIN = TD * GT;

    logic clk = 1'b0;
    logic rst_n;
    logic en, skip, hot, vbad, sw;
    logic [1:0] psu;
    logic pwr, alarm;
    logic [1:0] st;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    env_shutdown_ctrl #(.N_PSU(2), .TICK_DIV(TD), .GRACE_TICKS(GT), .DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_auto_en(en), .cfg_skip_psu(skip),
        .temp_hot(hot), .volt_bad(vbad), .psu_present(psu), .pwr_switch(sw),
        .power_on(pwr), .crit_alarm(alarm), .state_o(st)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk_state(input logic [1:0] exp, input string tag);
        logic ep, ea;
        ep = (exp == 2'd0) || (exp == 2'd1);
        ea = (exp == 2'd1) || (exp == 2'd2);
        n_tests++;
        if (st !== exp || pwr !== ep || alarm !== ea) begin
            n_fail++;
            $display("FAIL %s: state/power/alarm act=%0d/%0b/%0b exp=%0d/%0b/%0b",
                     tag, st, pwr, alarm, exp, ep, ea);
        end
    endtask

    function automatic logic [1:0] mdl_next(input logic [1:0] s, input logic e, k, h, v,
                                            input logic [1:0] p, input int cd);
        logic flt, miss;
        flt  = e && (h || v);
        miss = e && !k && (p != 2'b11);
        case (s)
            2'd0: mdl_next = flt ? 2'd2 : (miss ? 2'd1 : 2'd0);
            2'd1: mdl_next = flt ? 2'd2 : (!miss ? 2'd0 : (cd == NWIN - 1 ? 2'd2 : 2'd1));
            default: mdl_next = s;
        endcase
    endfunction

    task automatic rearm(input string tag);
        sw = 1'b0;
        step(DEB + 6);
        chk_state(2'd3, tag);
        step(4);
        chk_state(2'd3, tag);
        sw = 1'b1;
        step(DEB + 6);
        chk_state(2'd0, tag);
    endtask

    initial begin
        step(150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] mst, nxt;
        int cd;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; en = 1'b1; skip = 1'b0; hot = 1'b0; vbad = 1'b0;
        psu = 2'b11; sw = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk_state(2'd0, "R9 reset");

        // R2 temperature trip, then R7 latch and R8 glitch rejection
        hot = 1'b1; step(1); chk_state(2'd2, "R2 temp trip");
        hot = 1'b0; en = 1'b0; step(5); chk_state(2'd2, "R7 latched after clear");
        en = 1'b1;
        sw = 1'b0; step(3); sw = 1'b1; step(DEB + 6);
        chk_state(2'd2, "R8 short switch glitch");
        rearm("R7 rearm");

        // R3 voltage trip
        vbad = 1'b1; step(1); chk_state(2'd3 - 2'd1, "R3 volt trip");
        vbad = 1'b0; rearm("R7 rearm after volt");

        // R4 full countdown expiry
        psu = 2'b10; step(1); chk_state(2'd1, "R4 countdown entry");
        step(NWIN - 1); chk_state(2'd1, "R4 last countdown cycle");
        step(1); chk_state(2'd2, "R4 expiry trip");
        psu = 2'b11; rearm("R7 rearm after expiry");

        // R5 reinsertion in the expiry cycle, then full restart
        psu = 2'b01; step(1); step(NWIN - 1);
        psu = 2'b11; step(1); chk_state(2'd0, "R5 reinsert at final cycle");
        psu = 2'b01; step(1); step(NWIN - 1); chk_state(2'd1, "R5 countdown restarted");
        psu = 2'b11; step(1); chk_state(2'd0, "R5 reinsert");

        // R6 skip removal trip
        skip = 1'b1; psu = 2'b00; step(NWIN + 10); chk_state(2'd0, "R6 removal ignored");
        hot = 1'b1; step(1); chk_state(2'd2, "R6 temp still trips");
        hot = 1'b0; skip = 1'b0; psu = 2'b11; rearm("R7 rearm after skip");

        // R1 disabled
        en = 1'b0; hot = 1'b1; vbad = 1'b1; psu = 2'b00;
        step(NWIN + 10); chk_state(2'd0, "R1 disabled no action");
        hot = 1'b0; vbad = 1'b0; psu = 2'b11; en = 1'b1; step(1);

        // R10 disable during countdown
        psu = 2'b01; step(4); chk_state(2'd1, "R10 in countdown");
        en = 1'b0; step(1); chk_state(2'd0, "R10 disable cancels");
        en = 1'b1; psu = 2'b11; step(1); chk_state(2'd0, "R10 back active");

        // R11 fault and removal in same cycle
        psu = 2'b10; hot = 1'b1; step(1); chk_state(2'd2, "R11 fault wins over removal");
        hot = 1'b0; psu = 2'b11; rearm("R7 rearm after R11");

        // Random phase against reference model
        mst = 2'd0; cd = 0;
        for (int c = 0; c < 4000; c++) begin
            if (($urandom % 60) == 0) hot = 1'b1; else hot = 1'b0;
            if (($urandom % 60) == 0) vbad = 1'b1; else vbad = 1'b0;
            if (($urandom % 12) == 0) psu[0] = ~psu[0];
            if (($urandom % 12) == 0) psu[1] = ~psu[1];
            if (($urandom % 100) == 0) en = ~en;
            if (($urandom % 150) == 0) skip = ~skip;
            nxt = mdl_next(mst, en, skip, hot, vbad, psu, cd);
            cd  = (nxt == 2'd1 && mst == 2'd1) ? cd + 1 : 0;
            mst = nxt;
            step(1);
            chk_state(mst, "R2/R4/R5/R11 random model");
            if (mst == 2'd2) begin
                hot = 1'b0; vbad = 1'b0; psu = 2'b11; en = 1'b1; skip = 1'b0;
                rearm("R7 random rearm");
                mst = 2'd0; cd = 0;
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule